// File: doc/BRIEF.md
# Exception Context System Register Bank

This block is the system register bank of a small 32-bit processor core. It holds the processor status word, a two-half cause register, a table-call base pointer and four save pairs. Each save pair belongs to one kind of event: a maskable interrupt or software exception, a non-maskable interrupt, a table-call instruction, or an illegal-instruction trap. When the core raises the strobe for one of these events, the bank copies the current program counter and the status word it holds into the pair for that event.

Software reaches every register through a 5-bit register number. A load port returns the selected register combinationally. A store port writes the selected register on the next clock edge. Instruction decode, vector generation and return sequencing sit outside this block. The status word and the table base are also driven out as ports, so the rest of the core can use them.

Top module: `exc_ctx_regfile`

## Requirements
- R1: After reset every register reads zero, and `stat_o` and `tbl_base_o` are zero.
- R2: Register numbers are fixed: interrupt pair PC=0 and PSW=1, NMI pair PC=2 and PSW=3, cause=4, status word=5, table-call pair PC=16 and PSW=17, trap pair PC=18 and PSW=19, table base=20. A store to any of these numbers is read back unchanged through the load port.
- R3: Numbers 6 to 15 and 21 to 31 are reserved. A load from a reserved number returns zero, and a store to one changes no register.
- R4: `ev_int` saves `cur_pc` into register 0 and the status word into register 1. It writes `ev_code` into cause bits 15:0 and leaves bits 31:16 unchanged.
- R5: `ev_nmi` saves `cur_pc` into register 2 and the status word into register 3. It writes `ev_code` into cause bits 31:16 and leaves bits 15:0 unchanged.
- R6: `ev_call` saves `cur_pc` into register 16 and the status word into register 17. The cause register is unchanged.
- R7: `ev_trap` saves `cur_pc` into register 18 and the status word into register 19. The cause register is unchanged.
- R8: There is only one interrupt pair, so a later interrupt overwrites the values saved by an earlier one.
- R9: When several strobes are high in one cycle, only the highest-priority event is saved. The order is NMI, then trap, then interrupt, then table call. The registers of the other events stay as they were.
- R10: A hardware save beats a store to the same register in the same cycle. A store to any other register in that cycle still takes effect.
- R11: `stat_o` always equals register 5, and `tbl_base_o` always equals register 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_num | input | 5 | Register number for the load port |
| ld_data | output | 32 | Combinational read data |
| st_en | input | 1 | Store strobe |
| st_num | input | 5 | Register number for the store port |
| st_data | input | 32 | Store data |
| ev_int | input | 1 | Maskable interrupt or software exception taken |
| ev_nmi | input | 1 | Non-maskable interrupt taken |
| ev_call | input | 1 | Table-call instruction executed |
| ev_trap | input | 1 | Illegal-instruction trap taken |
| ev_code | input | 16 | Exception code for the cause register |
| cur_pc | input | 32 | Program counter to be saved |
| stat_o | output | 32 | Current status word |
| tbl_base_o | output | 32 | Table-call base pointer |

## Verification
The assertions assume that the event strobes, `ev_code` and `cur_pc` are known and stable around each rising edge. They also assume that `ld_num` changes only between edges, because the reserved-read check samples `ld_data` at the edge. The bench drives every input on the falling edge and holds it for the whole cycle. It raises combinations of strobes only in deliberate priority tests, and it reads state back only through the load port in a later cycle.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;

    localparam int NUM_W  = 5;
    localparam int NUM_EV = 4;

    typedef enum logic [1:0] {
        EV_INT  = 2'd0,
        EV_NMI  = 2'd1,
        EV_CALL = 2'd2,
        EV_TRAP = 2'd3
    } ev_kind_e;

    localparam logic [NUM_W-1:0] RN_CAUSE = 5'd4;
    localparam logic [NUM_W-1:0] RN_STAT  = 5'd5;
    localparam logic [NUM_W-1:0] RN_TBASE = 5'd20;

    // Register number of the PC half of each save pair; the PSW half follows it.
    function automatic logic [NUM_W-1:0] pair_pc_num(input int k);
        case (k)
            0:       return 5'd0;
            1:       return 5'd2;
            2:       return 5'd16;
            default: return 5'd18;
        endcase
    endfunction

    function automatic logic [NUM_W-1:0] pair_psw_num(input int k);
        return pair_pc_num(k) + 5'd1;
    endfunction

    // Save priority: rank 0 wins.
    function automatic int ev_at_rank(input int r);
        case (r)
            0:       return int'(EV_NMI);
            1:       return int'(EV_TRAP);
            2:       return int'(EV_INT);
            default: return int'(EV_CALL);
        endcase
    endfunction

    function automatic logic is_reserved(input logic [NUM_W-1:0] n);
        return ((n >= 5'd6) && (n <= 5'd15)) || (n >= 5'd21);
    endfunction

endpackage

// File: rtl/exc_ctx_arb.sv
module exc_ctx_arb
    import exc_ctx_pkg::*;
(
    input  logic [NUM_EV-1:0] req,
    output logic [NUM_EV-1:0] grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int r = 0; r < NUM_EV; r++) begin
            if (!found && req[ev_at_rank(r)]) begin
                grant[ev_at_rank(r)] = 1'b1;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_ctx_rmux.sv
module exc_ctx_rmux
    import exc_ctx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [NUM_W-1:0]             rd_num,
    input  logic [NUM_EV-1:0][XLEN-1:0]  spc,
    input  logic [NUM_EV-1:0][XLEN-1:0]  spsw,
    input  logic [XLEN-1:0]              cause,
    input  logic [XLEN-1:0]              stat,
    input  logic [XLEN-1:0]              tbase,
    output logic [XLEN-1:0]              rd_data
);
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_EV; k++) begin
            if (rd_num == pair_pc_num(k))  rd_data = spc[k];
            if (rd_num == pair_psw_num(k)) rd_data = spsw[k];
        end
        if (rd_num == RN_CAUSE) rd_data = cause;
        if (rd_num == RN_STAT)  rd_data = stat;
        if (rd_num == RN_TBASE) rd_data = tbase;
    end
endmodule

// File: rtl/exc_ctx_regfile.sv
module exc_ctx_regfile
    import exc_ctx_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_W-1:0]      ld_num,
    output logic [XLEN-1:0]       ld_data,
    input  logic                  st_en,
    input  logic [NUM_W-1:0]      st_num,
    input  logic [XLEN-1:0]       st_data,
    input  logic                  ev_int,
    input  logic                  ev_nmi,
    input  logic                  ev_call,
    input  logic                  ev_trap,
    input  logic [CODE_W-1:0]     ev_code,
    input  logic [XLEN-1:0]       cur_pc,
    output logic [XLEN-1:0]       stat_o,
    output logic [XLEN-1:0]       tbl_base_o
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic [NUM_EV-1:0][XLEN-1:0] spc;
        logic [NUM_EV-1:0][XLEN-1:0] spsw;
        logic [XLEN-1:0]             cause;
        logic [XLEN-1:0]             stat;
        logic [XLEN-1:0]             tbase;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_EV-1:0] ev_req;
    logic [NUM_EV-1:0] ev_grant;
    logic              cause_hit;

    always_comb begin
        ev_req          = '0;
        ev_req[EV_INT]  = ev_int;
        ev_req[EV_NMI]  = ev_nmi;
        ev_req[EV_CALL] = ev_call;
        ev_req[EV_TRAP] = ev_trap;
    end

    exc_ctx_arb u_arb (
        .req   (ev_req),
        .grant (ev_grant)
    );

    assign cause_hit = ev_grant[EV_INT] | ev_grant[EV_NMI];

    always_comb begin
        s_d = s_q;
        // software store; a capture of the same register masks it
        if (st_en) begin
            for (int k = 0; k < NUM_EV; k++) begin
                if (st_num == pair_pc_num(k) && !ev_grant[k])  s_d.spc[k]  = st_data;
                if (st_num == pair_psw_num(k) && !ev_grant[k]) s_d.spsw[k] = st_data;
            end
            if (st_num == RN_CAUSE && !cause_hit) s_d.cause = st_data;
            if (st_num == RN_STAT)                s_d.stat  = st_data;
            if (st_num == RN_TBASE)               s_d.tbase = st_data;
        end
        // hardware capture
        for (int k = 0; k < NUM_EV; k++) begin
            if (ev_grant[k]) begin
                s_d.spc[k]  = cur_pc;
                s_d.spsw[k] = s_q.stat;
            end
        end
        if (ev_grant[EV_NMI]) s_d.cause[XLEN-1:HALF] = ev_code[HALF-1:0];
        if (ev_grant[EV_INT]) s_d.cause[HALF-1:0]    = ev_code[HALF-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    exc_ctx_rmux #(.XLEN(XLEN)) u_rmux (
        .rd_num  (ld_num),
        .spc     (s_q.spc),
        .spsw    (s_q.spsw),
        .cause   (s_q.cause),
        .stat    (s_q.stat),
        .tbase   (s_q.tbase),
        .rd_data (ld_data)
    );

    assign stat_o     = s_q.stat;
    assign tbl_base_o = s_q.tbase;

    // ---------------- assertions ----------------
    p_rsvd_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_reserved(ld_num) |-> ld_data == '0);

    p_rsvd_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && is_reserved(st_num) && ev_req == '0) |=> s_q == $past(s_q));

    p_int_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_int && !ev_nmi && !ev_trap) |=>
            (s_q.spc[EV_INT] == $past(cur_pc)) && (s_q.spsw[EV_INT] == $past(s_q.stat))
            && (s_q.cause[XLEN-1:HALF] == $past(s_q.cause[XLEN-1:HALF])));

    p_nmi_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nmi |=> (s_q.spc[EV_NMI] == $past(cur_pc))
            && (s_q.cause[XLEN-1:HALF] == $past(ev_code[HALF-1:0]))
            && (s_q.cause[HALF-1:0] == $past(s_q.cause[HALF-1:0])));

    p_trap_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_trap && !ev_nmi) |=> (s_q.spc[EV_TRAP] == $past(cur_pc))
            && (s_q.cause == $past(s_q.cause)));

    p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_grant) && ((ev_grant & ~ev_req) == '0));

    p_nmi_blocks_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nmi && ev_int) |=> s_q.spc[EV_INT] == $past(s_q.spc[EV_INT]));

    p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_call && !ev_nmi && !ev_trap && !ev_int && st_en && st_num == pair_pc_num(int'(EV_CALL)))
            |=> s_q.spc[EV_CALL] == $past(cur_pc));

endmodule

// File: tb/exc_ctx_regfile_bench.sv
module exc_ctx_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ld_num = '0;
    logic [31:0] ld_data;
    logic        st_en = 1'b0;
    logic [4:0]  st_num = '0;
    logic [31:0] st_data = '0;
    logic        ev_int = 1'b0, ev_nmi = 1'b0, ev_call = 1'b0, ev_trap = 1'b0;
    logic [15:0] ev_code = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] stat_o, tbl_base_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_ctx_regfile u_exc_ctx_regfile (
        .clk(clk), .rst_n(rst_n),
        .ld_num(ld_num), .ld_data(ld_data),
        .st_en(st_en), .st_num(st_num), .st_data(st_data),
        .ev_int(ev_int), .ev_nmi(ev_nmi), .ev_call(ev_call), .ev_trap(ev_trap),
        .ev_code(ev_code), .cur_pc(cur_pc),
        .stat_o(stat_o), .tbl_base_o(tbl_base_o)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [4:0] n, input logic [31:0] exp);
        ld_num = n;
        #1;
        cmp(tag, ld_data, exp);
    endtask

    // one clock with events {nmi,trap,int,call} and an optional store
    task automatic cyc(input logic [3:0] ev, input logic [15:0] code, input logic [31:0] pc,
                       input logic se, input logic [4:0] sn, input logic [31:0] sd);
        {ev_nmi, ev_trap, ev_int, ev_call} = ev;
        ev_code = code; cur_pc = pc;
        st_en = se; st_num = sn; st_data = sd;
        @(posedge clk);
        @(negedge clk);
        {ev_nmi, ev_trap, ev_int, ev_call} = '0;
        st_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] n, input logic [31:0] d);
        cyc(4'b0000, '0, '0, 1'b1, n, d);
    endtask

    task automatic t_reset;
        for (int n = 0; n < 32; n++) rd("R1 reset read", 5'(n), 32'h0);
        cmp("R1 stat_o", stat_o, 32'h0);
        cmp("R1 tbl_base_o", tbl_base_o, 32'h0);
    endtask

    task automatic t_map;
        logic [4:0] nums [11] = '{0, 1, 2, 3, 4, 5, 16, 17, 18, 19, 20};
        foreach (nums[i]) wr(nums[i], 32'hA000_0000 | 32'(nums[i]));
        foreach (nums[i]) rd("R2 store/load", nums[i], 32'hA000_0000 | 32'(nums[i]));
        cmp("R11 stat_o", stat_o, 32'hA000_0005);
        cmp("R11 tbl_base_o", tbl_base_o, 32'hA000_0014);
    endtask

    task automatic t_reserved;
        logic [4:0] rs [4] = '{6, 15, 21, 31};
        foreach (rs[i]) wr(rs[i], 32'hFFFF_FFFF);
        foreach (rs[i]) rd("R3 reserved read", rs[i], 32'h0);
        for (int n = 0; n < 6; n++) rd("R3 store left regs alone", 5'(n), 32'hA000_0000 | n);
        for (int n = 16; n < 21; n++) rd("R3 store left regs alone", 5'(n), 32'hA000_0000 | n);
    endtask

    task automatic t_int;
        wr(5, 32'h0000_00A5);
        wr(4, 32'hDEAD_BEEF);
        cyc(4'b0010, 16'h0040, 32'h0000_1000, 1'b0, '0, '0);
        rd("R4 pc", 0, 32'h0000_1000);
        rd("R4 psw", 1, 32'h0000_00A5);
        rd("R4 cause", 4, 32'hDEAD_0040);
    endtask

    task automatic t_nmi;
        cyc(4'b1000, 16'h0010, 32'h0000_2000, 1'b0, '0, '0);
        rd("R5 pc", 2, 32'h0000_2000);
        rd("R5 psw", 3, 32'h0000_00A5);
        rd("R5 cause", 4, 32'h0010_0040);
        rd("R5 int pair kept", 0, 32'h0000_1000);
    endtask

    task automatic t_call;
        cyc(4'b0001, 16'h0033, 32'h0000_3000, 1'b0, '0, '0);
        rd("R6 pc", 16, 32'h0000_3000);
        rd("R6 psw", 17, 32'h0000_00A5);
        rd("R6 cause kept", 4, 32'h0010_0040);
    endtask

    task automatic t_trap;
        cyc(4'b0100, 16'h0044, 32'h0000_4000, 1'b0, '0, '0);
        rd("R7 pc", 18, 32'h0000_4000);
        rd("R7 psw", 19, 32'h0000_00A5);
        rd("R7 cause kept", 4, 32'h0010_0040);
    endtask

    task automatic t_nest;
        cyc(4'b0010, 16'h0050, 32'h0000_1100, 1'b0, '0, '0);
        wr(5, 32'h0000_005A);
        cyc(4'b0010, 16'h0060, 32'h0000_1200, 1'b0, '0, '0);
        rd("R8 pc overwritten", 0, 32'h0000_1200);
        rd("R8 psw overwritten", 1, 32'h0000_005A);
        rd("R8 cause", 4, 32'h0010_0060);
    endtask

    task automatic t_prio;
        cyc(4'b1111, 16'h0070, 32'h0000_5000, 1'b0, '0, '0);
        rd("R9 nmi won", 2, 32'h0000_5000);
        rd("R9 int kept", 0, 32'h0000_1200);
        rd("R9 trap kept", 18, 32'h0000_4000);
        rd("R9 call kept", 16, 32'h0000_3000);
        rd("R9 cause", 4, 32'h0070_0060);
        cyc(4'b0111, 16'h0080, 32'h0000_6000, 1'b0, '0, '0);
        rd("R9 trap won", 18, 32'h0000_6000);
        rd("R9 int kept", 0, 32'h0000_1200);
        rd("R9 cause kept", 4, 32'h0070_0060);
        cyc(4'b0011, 16'h0090, 32'h0000_7000, 1'b0, '0, '0);
        rd("R9 int won", 0, 32'h0000_7000);
        rd("R9 call kept", 16, 32'h0000_3000);
        rd("R9 cause", 4, 32'h0070_0090);
    endtask

    task automatic t_clash;
        cyc(4'b0001, 16'h0000, 32'h0000_8000, 1'b1, 5'd16, 32'hFFFF_0000);
        rd("R10 call beats store", 16, 32'h0000_8000);
        cyc(4'b1000, 16'h00AA, 32'h0000_9000, 1'b1, 5'd4, 32'h1234_5678);
        rd("R10 nmi beats cause store", 4, 32'h00AA_0090);
        cyc(4'b0100, 16'h0000, 32'h0000_A000, 1'b1, 5'd20, 32'h0000_C0DE);
        rd("R10 trap saved", 18, 32'h0000_A000);
        rd("R10 other store taken", 20, 32'h0000_C0DE);
        cmp("R11 tbl_base_o follows", tbl_base_o, 32'h0000_C0DE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_map;
        t_reserved;
        t_int;
        t_nmi;
        t_call;
        t_trap;
        t_nest;
        t_prio;
        t_clash;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule